// File: doc/BRIEF.md
# Transition-Compressing Timing Capture Path

This block is the storage front end of a timing-mode capture channel. A programmable divider turns the system clock into a sample cadence. At each sample point the block looks at a bus of input channels and decides whether that sample goes to the downstream capture memory. The memory itself is not part of this block. A sample that is kept appears for one clock on a write strobe, together with the sampled word and a time-marker word.

There are two capture modes. Continuous mode keeps every sample. Transition mode keeps a sample only when the channel word differs from the previous sample point. The time marker counts sample points since the capture was armed. Downstream logic can therefore rebuild the gaps between kept samples.

A start pulse arms or re-arms capture. A change of the mode input has the same effect. Three kinds of sample are always kept: the first sample after arming, which sets the reference state; any sample taken while the marker sits at its top value, so that counter wraps can be detected; and, in continuous mode, every sample.

Top module: `tsc_top`

## Requirements
- R1: After reset and before the first start pulse, `wr_en` stays low whatever the channels do. After reset, `wr_data` and `wr_mark` read zero.
- R2: Let the period P be `div_n`, with a `div_n` of 0 treated as 1. If `start` is high at clock edge E0, the channels are sampled at edges E0+1, E0+1+P, E0+1+2P and so on. A kept sample shows `wr_en` high just after its sampling edge. `wr_en` is low at every edge between sample points.
- R3: With `mode_sel` = 0 (continuous), every sample point is written, and `wr_data` equals the channel word at that edge.
- R4: With `mode_sel` = 1 (transition), a sample equal to the previous sample point's word is not written, unless R5 or R7 applies. A sample that differs from it is written.
- R5: The first sample point after arming is always written, in both modes.
- R6: `wr_mark` holds the index k of the sample point since arming (the first is 0), taken modulo 2^MARK_W.
- R7: In transition mode, a sample point whose index modulo 2^MARK_W equals 2^MARK_W-1 is written even when the channels have not changed.
- R8: A change on `mode_sel` re-arms capture like a start pulse. No write comes from the re-arming edge, the index restarts at 0, and the next sample point is the first.
- R9: A start pulse during a running capture re-arms it. No write comes from that edge, and the index and first-sample rule start over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms or re-arms capture |
| mode_sel | input | 1 | 0 = continuous, 1 = transition |
| div_n | input | DIV_W | Sample period in clocks (0 acts as 1) |
| chan_in | input | CH_W | Channel word being observed |
| wr_en | output | 1 | One-clock write strobe for capture memory |
| wr_data | output | CH_W | Sampled channel word |
| wr_mark | output | MARK_W | Time marker of the written sample |

## Verification
A re-arming edge (start or mode change) produces no write. The first sample is taken at the next edge, and its result is visible one clock after that edge. Each later result falls exactly P edges after the previous one. The bench drives inputs at falling edges and steps through sample points one period at a time. It compares `wr_en`, `wr_data` and `wr_mark` at the falling edge just after each sampling edge, and it also checks that `wr_en` is low at every falling edge in between. The marker-wrap case runs 258 sample points of an unchanging word, so that the forced write lands at index 255.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic {
        CAP_CONT  = 1'b0,
        CAP_TRANS = 1'b1
    } cap_mode_e;
endpackage

// File: rtl/tsc_rate_gen.sv
module tsc_rate_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } rg_st_t;

    rg_st_t           st_d, st_q;
    logic [DIV_W-1:0] period;

    always_comb begin
        st_d   = st_q;
        period = (div_n == '0) ? ONE : div_n;
        tick   = run && !clear && (st_q.cnt == '0);
        if (clear) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (st_q.cnt >= period - ONE) st_d.cnt = '0;
            else                          st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a period above one leaves a quiet cycle after every sample point
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_n > ONE) |=> !tick);
    // R1: no sample points while not armed
    a_r1_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);
endmodule

// File: rtl/tsc_marker.sv
module tsc_marker #(
    parameter int MARK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    output logic [MARK_W-1:0] mark,
    output logic              at_max
);
    localparam logic [MARK_W-1:0] MARK_ONE = MARK_W'(1);

    typedef struct packed {
        logic [MARK_W-1:0] cnt;
    } mk_st_t;

    mk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)     st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + MARK_ONE;
        mark   = st_q.cnt;
        at_max = &st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: each sample point advances the marker by one, wrapping
    a_r6_mark_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> (mark == $past(mark) + MARK_ONE));
    // R8: re-arming zeroes the marker
    a_r8_mark_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mark == '0));
endmodule

// File: rtl/tsc_store_ctl.sv
module tsc_store_ctl
    import tsc_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int MARK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    input  cap_mode_e         mode,
    input  logic [CH_W-1:0]   chan_in,
    input  logic [MARK_W-1:0] mark,
    input  logic              at_max,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_data,
    output logic [MARK_W-1:0] wr_mark
);
    typedef struct packed {
        logic [CH_W-1:0]   prev;
        logic              first;
        logic              wr_en;
        logic [CH_W-1:0]   wr_data;
        logic [MARK_W-1:0] wr_mark;
    } sc_st_t;

    sc_st_t st_d, st_q;
    logic   changed;
    logic   keep;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        changed    = (chan_in != st_q.prev);
        keep       = (mode == CAP_CONT) || st_q.first || changed || at_max;
        if (clear) begin
            st_d.prev  = '0;
            st_d.first = 1'b1;
        end else if (tick) begin
            st_d.prev  = chan_in;
            st_d.first = 1'b0;
            if (keep) begin
                st_d.wr_en   = 1'b1;
                st_d.wr_data = chan_in;
                st_d.wr_mark = mark;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = st_q.wr_en;
    assign wr_data = st_q.wr_data;
    assign wr_mark = st_q.wr_mark;

    // R3: continuous mode writes every sample point
    a_r3_cont_all: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == CAP_CONT) |=> wr_en);
    // R4: an unchanged word in transition mode is dropped
    a_r4_quiet_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == CAP_TRANS && !st_q.first && chan_in == st_q.prev && !at_max)
        |=> !wr_en);
    // R5: the first sample after arming is written
    a_r5_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.first) |=> wr_en);
    // R7: a marker at its top value forces a write
    a_r7_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_max) |=> wr_en);
    // R2: writes only follow sample points
    a_r2_write_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !wr_en);
endmodule

// File: rtl/tsc_top.sv
module tsc_top
    import tsc_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int MARK_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_sel,
    input  logic [DIV_W-1:0]  div_n,
    input  logic [CH_W-1:0]   chan_in,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_data,
    output logic [MARK_W-1:0] wr_mark
);
    typedef struct packed {
        logic      active;
        cap_mode_e mode;
    } top_st_t;

    top_st_t           st_d, st_q;
    cap_mode_e         mode_in;
    logic              rearm;
    logic              tick;
    logic [MARK_W-1:0] mark;
    logic              at_max;

    always_comb begin
        mode_in = cap_mode_e'(mode_sel);
        rearm   = start || (mode_in != st_q.mode);
        st_d        = st_q;
        st_d.mode   = mode_in;
        if (start) st_d.active = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, mode: CAP_CONT};
        else        st_q <= st_d;
    end

    tsc_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rearm),
        .run   (st_q.active),
        .div_n (div_n),
        .tick  (tick)
    );

    tsc_marker #(.MARK_W(MARK_W)) u_mark (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rearm),
        .tick   (tick),
        .mark   (mark),
        .at_max (at_max)
    );

    tsc_store_ctl #(.CH_W(CH_W), .MARK_W(MARK_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rearm),
        .tick    (tick),
        .mode    (st_q.mode),
        .chan_in (chan_in),
        .mark    (mark),
        .at_max  (at_max),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mark (wr_mark)
    );

    // R1: nothing is written before capture is first armed
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !start) |=> !wr_en);
    // R9: the re-arming edge itself never writes
    a_r9_rearm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !wr_en);
endmodule

// File: tb/tsc_top_tb.sv
module tsc_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode_sel = 1'b0;
    logic [7:0] div_n = 8'd1;
    logic [7:0] chan_in = 8'd0;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] wr_mark;

    int  n_chk = 0;
    int  n_bad = 0;
    int  per = 1;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    tsc_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
        .div_n(div_n), .chan_in(chan_in),
        .wr_en(wr_en), .wr_data(wr_data), .wr_mark(wr_mark)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // re-arm by start pulse; called at a falling edge
    task automatic pulse_start(input string req);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(req, wr_en, 0);
    endtask

    // re-arm by mode change; called at a falling edge
    task automatic change_mode(input logic m, input string req);
        mode_sel = m;
        @(negedge clk);
        chk(req, wr_en, 0);
    endtask

    // one sample point: drive word, check result after the sampling edge, then quiet cycles
    task automatic step(input logic [7:0] val, input bit exp_wr, input int k, input string req);
        chan_in = val;
        @(negedge clk);
        chk(req, wr_en, exp_wr);
        if (exp_wr) begin
            chk(req, wr_data, val);
            chk("R6", wr_mark, k % 256);
        end
        for (int i = 1; i < per; i++) begin
            @(negedge clk);
            chk("R2", wr_en, 0);
        end
    endtask

    task automatic t_reset;
        chk("R1", wr_en, 0);
        chk("R1", wr_data, 0);
        chk("R1", wr_mark, 0);
        for (int i = 0; i < 10; i++) begin
            chan_in = 8'(i * 37);
            @(negedge clk);
            chk("R1", wr_en, 0);
        end
    endtask

    task automatic t_continuous;
        logic [7:0] v [5] = '{8'h11, 8'h22, 8'h22, 8'h33, 8'h44};
        mode_sel = 1'b0; div_n = 8'd3; per = 3;
        pulse_start("R2");
        for (int k = 0; k < 5; k++) step(v[k], 1'b1, k, "R3");
    endtask

    task automatic t_transition;
        logic [7:0] v [6] = '{8'hA5, 8'hA5, 8'h3C, 8'h3C, 8'h3C, 8'hF0};
        bit         w [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
        mode_sel = 1'b1; div_n = 8'd2; per = 2;
        pulse_start("R5");
        for (int k = 0; k < 6; k++) step(v[k], w[k], k, (k == 0) ? "R5" : "R4");
    endtask

    task automatic t_div_zero;
        mode_sel = 1'b0; div_n = 8'd0; per = 1;
        pulse_start("R2");
        for (int k = 0; k < 3; k++) step(8'(k + 1), 1'b1, k, "R2");
    endtask

    task automatic t_forced;
        mode_sel = 1'b1; div_n = 8'd1; per = 1;
        pulse_start("R5");
        for (int k = 0; k < 258; k++)
            step(8'h5A, (k == 0) || (k == 255), k, (k == 255) ? "R7" : "R4");
    endtask

    task automatic t_mode_change;
        change_mode(1'b0, "R8");
        for (int k = 0; k < 3; k++) step(8'h5A, 1'b1, k, "R8");
        change_mode(1'b1, "R8");
        step(8'h5A, 1'b1, 0, "R8");
        step(8'h5A, 1'b0, 1, "R8");
    endtask

    task automatic t_restart;
        mode_sel = 1'b1; div_n = 8'd2; per = 2;
        pulse_start("R9");
        step(8'h77, 1'b1, 0, "R9");
        step(8'h77, 1'b0, 1, "R9");
        pulse_start("R9");
        step(8'h77, 1'b1, 0, "R9");
        step(8'h77, 1'b0, 1, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_continuous();
        t_transition();
        t_div_zero();
        t_forced();
        t_mode_change();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule